// File: doc/BRIEF.md
# Static-Memory Strobe Timing Sequencer

This block turns one internal access request into the strobe waveform for a single chip-select area of an asynchronous static-memory bus. A request carries the address, write data, byte enables and direction. It is accepted with a valid/ready handshake while the block is idle. The block then drives the address and an active-low chip select. After a programmable setup delay it pulses the read or write strobes, and after a programmable hold delay it releases the chip select. Read data is sampled from the bus at the end of the strobe and returned with a one-tick completion pulse.

The block runs on a clock at twice the bus rate, so each fast tick is half a bus cycle. The setup and hold delays are therefore set in half-cycle steps of 0.5, 1.5, 2.5 or 3.5 bus cycles. A mode bit selects a second strobe scheme for SRAMs whose byte lanes are selected by their write-enable pins. In that scheme the per-byte write enables act as lane selects for the whole access, and the direction line carries the write pulse.

Top module: `sram_strobe_gen`

## Requirements
- R1: After reset the configuration reads 0, `bus_cs_n`, `bus_rd_n`, `bus_wr_n` and every `bus_we_n` bit are high, `req_ready` is high and `rsp_done` is low. The first access uses a 0.5-cycle setup, a 0.5-cycle hold and mode 0.
- R2: The configuration word has setup code S in bits [1:0], hold code H in bits [3:2] and the byte-select mode bit in bit 4. Bits [7:5] always read 0, and writing them has no effect.
- R3: The access starts on the tick after acceptance. `bus_cs_n` is low and the address is on `bus_addr` from then on, and the strobe asserts 2*S+1 fast ticks later.
- R4: The strobe phase lasts exactly two fast ticks (one bus cycle).
- R5: `bus_cs_n` stays low for 2*H+1 fast ticks after the strobe ends, then rises.
- R6: In mode 0, a write drives `bus_we_n` low on its enabled byte lanes during the strobe phase only. `bus_wr_n` (low = write) is low for the whole access and `bus_rd_n` stays high.
- R7: In mode 0, a read drives `bus_rd_n` low during the strobe phase only. `bus_we_n` and `bus_wr_n` stay high, and `bus_rd_n` and `bus_wr_n` are never low together.
- R8: In mode 1, `bus_we_n` is low on the enabled byte lanes for the whole access on both reads and writes. `bus_wr_n` is low only during the strobe phase of a write, and `bus_rd_n` is low only during the strobe phase of a read.
- R9: Read data is the value on `bus_din` on the last tick of the strobe phase. `rsp_done` pulses for exactly one tick, on the tick `bus_cs_n` rises, with that data on `rsp_rdata`.
- R10: `req_ready` is high only while idle. A request presented during an access is ignored and leaves the bus address unchanged.
- R11: A configuration write during an access does not change that access; it applies from the next accepted request.
- R12: `bus_addr` and `bus_dout` hold the request's values for the whole access, and `bus_dout_en` is high for the whole of a write access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twice the bus rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration read value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_be | input | DATA_W/8 | Request byte enables |
| rsp_done | output | 1 | One-tick completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Memory address |
| bus_dout | output | DATA_W | Memory write data |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Memory read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | DATA_W/8 | Per-byte write enables, active low |
| bus_wr_n | output | 1 | Direction line, low = write |

## Verification
The hardest case to reach is a configuration write landing in the middle of an access, combined with a second request arriving while the block is busy. Both happen only inside a window of a few fast ticks. The bench raises both on the second tick of a short access. It checks that this access keeps its old timing and address, and that the next access stretches to the new delays. The capture tick is pinned by changing `bus_din` every tick, so only the last strobe tick carries the expected value. All 64 combinations of setup, hold, mode and direction are swept.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

    localparam int CFG_W      = 8;
    localparam int DLY_W      = 2;
    localparam int SETUP_LSB  = 0;
    localparam int HOLD_LSB   = 2;
    localparam int MODE_BIT   = 4;
    localparam int USED_BITS  = 5;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [DLY_W-1:0] setup;
        logic [DLY_W-1:0] hold;
        logic             bytesel;
    } timing_cfg_t;

endpackage

// File: rtl/sram_strobe_cfg.sv
module sram_strobe_cfg
    import sram_strobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output timing_cfg_t      cfg
);
    localparam logic [CFG_W-1:0] USED_MASK = CFG_W'((1 << USED_BITS) - 1);

    logic [CFG_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (wr_en) begin
            word_d = wdata & USED_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign rdata       = word_q;
    assign cfg.setup   = word_q[SETUP_LSB +: DLY_W];
    assign cfg.hold    = word_q[HOLD_LSB +: DLY_W];
    assign cfg.bytesel = word_q[MODE_BIT];

    assert_cfg_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg.setup == $past(wdata[SETUP_LSB +: DLY_W]) &&
                   cfg.hold == $past(wdata[HOLD_LSB +: DLY_W]) &&
                   cfg.bytesel == $past(wdata[MODE_BIT])));

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
    import sram_strobe_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    localparam int NB    = DATA_W / 8,
    localparam int CNT_W = DLY_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  timing_cfg_t       cfg_live,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [NB-1:0]     req_be,
    input  logic [DATA_W-1:0] bus_din,
    output phase_e            phase_d_o,
    output logic              write_d_o,
    output logic [NB-1:0]     be_d_o,
    output logic              bytesel_d_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o
);
    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        timing_cfg_t       cfg;
        logic              write;
        logic [NB-1:0]     be;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    seq_d.phase = PH_SETUP;
                    seq_d.cfg   = cfg_live;
                    seq_d.cnt   = {cfg_live.setup, 1'b0};
                    seq_d.write = req_write;
                    seq_d.be    = req_be;
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                end
            end
            PH_SETUP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_STROBE;
                    seq_d.cnt   = CNT_W'(1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_HOLD;
                    seq_d.cnt   = {seq_q.cfg.hold, 1'b0};
                    if (!seq_q.write) begin
                        seq_d.rdata = bus_din;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_IDLE;
                    seq_d.done  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready   = (seq_q.phase == PH_IDLE);
    assign phase_d_o   = seq_d.phase;
    assign write_d_o   = seq_d.write;
    assign be_d_o      = seq_d.be;
    assign bytesel_d_o = seq_d.cfg.bytesel;
    assign addr_o      = seq_q.addr;
    assign wdata_o     = seq_q.wdata;
    assign rdata_o     = seq_q.rdata;
    assign done_o      = seq_q.done;

    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase != PH_IDLE && $past(seq_q.phase) != PH_IDLE) |-> $stable(seq_q.cfg));

    assert_addr_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase != PH_IDLE && $past(seq_q.phase) != PH_IDLE) |-> $stable(addr_o));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/sram_strobe_drive.sv
module sram_strobe_drive
    import sram_strobe_pkg::*;
#(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase_d,
    input  logic          write_d,
    input  logic [NB-1:0] be_d,
    input  logic          bytesel_d,
    output logic          cs_n,
    output logic          rd_n,
    output logic [NB-1:0] we_n,
    output logic          wr_n,
    output logic          dout_en
);
    typedef struct packed {
        logic          cs_n;
        logic          rd_n;
        logic [NB-1:0] we_n;
        logic          wr_n;
        logic          dout_en;
    } pins_s;

    pins_s pins_d, pins_q;
    logic  active, strobe;

    always_comb begin
        active         = (phase_d != PH_IDLE);
        strobe         = (phase_d == PH_STROBE);
        pins_d.cs_n    = !active;
        pins_d.rd_n    = !(strobe && !write_d);
        pins_d.dout_en = active && write_d;
        if (bytesel_d) begin
            pins_d.we_n = active ? ~be_d : '1;
            pins_d.wr_n = !(strobe && write_d);
        end else begin
            pins_d.we_n = (strobe && write_d) ? ~be_d : '1;
            pins_d.wr_n = !(active && write_d);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '{cs_n: 1'b1, rd_n: 1'b1, we_n: '1, wr_n: 1'b1, dout_en: 1'b0};
        end else begin
            pins_q <= pins_d;
        end
    end

    assign cs_n    = pins_q.cs_n;
    assign rd_n    = pins_q.rd_n;
    assign we_n    = pins_q.we_n;
    assign wr_n    = pins_q.wr_n;
    assign dout_en = pins_q.dout_en;

    assert_rd_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n);

    assert_rd_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |=> (!rd_n ##1 rd_n));

endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
    import sram_strobe_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    localparam int NB    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [NB-1:0]     req_be,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic [NB-1:0]     bus_we_n,
    output logic              bus_wr_n
);
    timing_cfg_t   cfg_live;
    phase_e        phase_d;
    logic          write_d;
    logic [NB-1:0] be_d;
    logic          bytesel_d;

    sram_strobe_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg_live)
    );

    sram_strobe_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_live    (cfg_live),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_be      (req_be),
        .bus_din     (bus_din),
        .phase_d_o   (phase_d),
        .write_d_o   (write_d),
        .be_d_o      (be_d),
        .bytesel_d_o (bytesel_d),
        .addr_o      (bus_addr),
        .wdata_o     (bus_dout),
        .rdata_o     (rsp_rdata),
        .done_o      (rsp_done)
    );

    sram_strobe_drive #(.NB(NB)) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_d   (phase_d),
        .write_d   (write_d),
        .be_d      (be_d),
        .bytesel_d (bytesel_d),
        .cs_n      (bus_cs_n),
        .rd_n      (bus_rd_n),
        .we_n      (bus_we_n),
        .wr_n      (bus_wr_n),
        .dout_en   (bus_dout_en)
    );

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |-> !req_ready);

    assert_rd_wr_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    assert_done_ends_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (bus_cs_n && $past(!bus_cs_n)));

endmodule

// File: tb/sram_strobe_gen_tb.sv
module sram_strobe_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 16;
    localparam int NB         = DATA_W / 8;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic [7:0]        cfg_rdata;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [NB-1:0]     req_be = '0;
    logic              rsp_done;
    logic [DATA_W-1:0] rsp_rdata;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_dout;
    logic              bus_dout_en;
    logic [DATA_W-1:0] bus_din = '0;
    logic              bus_cs_n;
    logic              bus_rd_n;
    logic [NB-1:0]     bus_we_n;
    logic              bus_wr_n;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sram_strobe_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .bus_din(bus_din), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_we_n(bus_we_n), .bus_wr_n(bus_wr_n)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            chk(1'b0, "WDOG", "watchdog expired", cycles, WATCHDOG);
            summary();
        end
    end

    task automatic cfg_write(input logic [7:0] val);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wdata = val;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // One access; s/h/m are the settings the bench expects it to run with.
    // disturb: on tick 1 present a stray request and rewrite the config (R10, R11).
    task automatic run_xfer(input bit wr, input int s, input int h, input bit m,
                            input logic [15:0] addr, input logic [15:0] wd,
                            input logic [1:0] be, input logic [15:0] rv,
                            input bit disturb, input logic [7:0] new_cfg);
        int total;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wd;
        req_be    = be;
        bus_din   = ~rv;
        @(negedge clk);
        req_valid = 1'b0;
        total = 2 * s + 2 * h + 4;
        for (int k = 0; k < total; k++) begin
            bit         stb;
            string      ctag;
            string      wtag;
            logic [1:0] exp_we;
            logic       exp_wr;
            logic       exp_rd;
            stb  = (k >= 2 * s + 1) && (k <= 2 * s + 2);
            ctag = (k <= 2 * s) ? "R3" : (stb ? "R4" : "R5");
            wtag = m ? "R8" : (wr ? "R6" : "R7");
            if (m) begin
                exp_we = ~be;
                exp_wr = !(stb && wr);
            end else begin
                exp_we = (stb && wr) ? ~be : 2'b11;
                exp_wr = !wr;
            end
            exp_rd = !(stb && !wr);
            chk(bus_cs_n == 1'b0, ctag, "cs_n", bus_cs_n, 0);
            chk(bus_rd_n == exp_rd, stb ? "R4" : "R7", "rd_n", bus_rd_n, exp_rd);
            chk(bus_we_n == exp_we, wtag, "we_n", bus_we_n, exp_we);
            chk(bus_wr_n == exp_wr, wtag, "wr_n", bus_wr_n, exp_wr);
            chk(bus_addr == addr, "R12", "addr", bus_addr, addr);
            chk(bus_dout_en == wr, "R12", "dout_en", bus_dout_en, wr);
            if (wr) chk(bus_dout == wd, "R12", "dout", bus_dout, wd);
            chk(req_ready == 1'b0, "R10", "ready busy", req_ready, 0);
            chk(rsp_done == 1'b0, "R9", "done early", rsp_done, 0);
            bus_din = (k == 2 * s + 2) ? rv : ~rv;
            if (disturb && k == 1) begin
                req_valid = 1'b1;
                req_addr  = ~addr;
                cfg_wr_en = 1'b1;
                cfg_wdata = new_cfg;
            end
            if (disturb && k == 2) begin
                req_valid = 1'b0;
                cfg_wr_en = 1'b0;
            end
            @(negedge clk);
        end
        chk(bus_cs_n == 1'b1, "R5", "cs_n release", bus_cs_n, 1);
        chk(rsp_done == 1'b1, "R9", "done pulse", rsp_done, 1);
        chk(bus_rd_n == 1'b1 && bus_wr_n == 1'b1 && bus_we_n == 2'b11, "R5",
            "strobes idle", {bus_rd_n, bus_wr_n, bus_we_n}, 4'hF);
        if (!wr) chk(rsp_rdata == rv, "R9", "rdata", rsp_rdata, rv);
        chk(req_ready == 1'b1, "R10", "ready idle", req_ready, 1);
        @(negedge clk);
        chk(rsp_done == 1'b0, "R9", "done width", rsp_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cfg_rdata == 8'h00, "R1", "cfg reset", cfg_rdata, 0);
        chk(bus_cs_n && bus_rd_n && bus_wr_n && bus_we_n == 2'b11, "R1", "pins reset",
            {bus_cs_n, bus_rd_n, bus_wr_n, bus_we_n}, 5'h1F);
        chk(req_ready == 1'b1 && rsp_done == 1'b0, "R1", "handshake reset",
            {req_ready, rsp_done}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 8'h00, "R1", "cfg after release", cfg_rdata, 0);
        // R1: defaults give 0.5 setup, 0.5 hold, mode 0
        run_xfer(1'b0, 0, 0, 1'b0, 16'h1234, 16'h0, 2'b11, 16'hBEEF, 1'b0, 8'h00);
        run_xfer(1'b1, 0, 0, 1'b0, 16'h4321, 16'hCAFE, 2'b01, 16'h0, 1'b0, 8'h00);

        // R2: field layout and unused bits
        cfg_write(8'hFF);
        chk(cfg_rdata == 8'h1F, "R2", "unused read 0", cfg_rdata, 8'h1F);
        cfg_write(8'hE0);
        chk(cfg_rdata == 8'h00, "R2", "unused no effect", cfg_rdata, 8'h00);
        cfg_write(8'h16);
        chk(cfg_rdata == 8'h16, "R2", "fields", cfg_rdata, 8'h16);

        // Sweep setup, hold, mode, direction (R3..R9, R12)
        for (int s = 0; s < 4; s++) begin
            for (int h = 0; h < 4; h++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int w = 0; w < 2; w++) begin
                        int         idx;
                        logic [1:0] be;
                        idx = ((s * 4 + h) * 2 + m) * 2 + w;
                        be  = 2'((idx % 3) + 1);
                        cfg_write({3'b000, m[0], h[1:0], s[1:0]});
                        run_xfer(w[0], s, h, m[0], 16'(16'h0100 + idx * 7),
                                 16'(16'h5A00 ^ idx), be, 16'(16'hA500 ^ idx),
                                 1'b0, 8'h00);
                    end
                end
            end
        end

        // R11 / R10: config rewrite and stray request during a short access
        cfg_write(8'h00);
        run_xfer(1'b0, 0, 0, 1'b0, 16'h0AAA, 16'h0, 2'b11, 16'h3C3C, 1'b1, 8'h1F);
        chk(cfg_rdata == 8'h1F, "R11", "cfg written mid-access", cfg_rdata, 8'h1F);
        run_xfer(1'b1, 3, 3, 1'b1, 16'h0BBB, 16'h7777, 2'b10, 16'h0, 1'b0, 8'h00);

        summary();
    end

endmodule